// File: doc/BRIEF.md
# Program/Erase Command Gate

This block stands between the command interpreter of a 50-block flash array and its program/erase controller. Every decoded program, block-erase, suspend or resume request passes through it. The gate decides whether the request goes ahead, tracks whether an operation is running, suspended or absent, and drives the ready/busy output. It checks each program or erase request against the block index, the hardware write-protect pin and the per-block lock bits. Block 49, the top block, answers to its lock bit alone.

A digital supply-lockout flag disables the gate. While the flag is set, every request is refused and any operation in flight is aborted. When the flag clears, the gate sends the command interpreter a one-cycle request to return to read mode. The write-protect level seen when an operation is accepted is latched and presented to the controller until the next accepted program or erase. Later movement of the pin cannot disturb an operation that is running or suspended.

All outputs are registered. A request presented at one clock edge is answered by an accept or an ignored pulse that is visible after that edge.

Top module: `pe_cmd_gate`

## Requirements
- R1: After reset, ready_busy is 1, op_wp_n is 1 and cmd_accept, cmd_ignored, abort_req and force_read are 0.
- R2: With wp_n at 0, a program (cmd_kind 2'b00) or erase (cmd_kind 2'b01) aimed at any block from 0 to 48 is ignored, whatever that block's lock bit holds.
- R3: With wp_n at 1, a program or erase aimed at block b (0 to 48) is accepted when lock_bits[b] is 0 and the gate is idle, and is ignored when lock_bits[b] is 1.
- R4: For block 49, wp_n has no effect: the request is accepted when lock_bits[49] is 0 and ignored when it is 1.
- R5: A program or erase whose block index is 50 or above is ignored.
- R6: After a program or erase is accepted, ready_busy reads 0 from the following cycle. It returns to 1 in the cycle after ctl_finish is seen while the operation runs.
- R7: While an operation runs, further program or erase requests are ignored. Suspend (cmd_kind 2'b10) is accepted, and ready_busy returns to 1 while suspended. Resume (cmd_kind 2'b11) is accepted only while suspended, and ready_busy returns to 0. A program or erase issued while suspended is ignored. A suspend arriving together with ctl_finish is ignored.
- R8: While supply_low is 1, every request is ignored and ready_busy is 1. If an operation was running or suspended when supply_low is first seen, abort_req pulses for exactly one cycle.
- R9: In the cycle after supply_low is first seen at 0 following a 1, force_read pulses for one cycle.
- R10: op_wp_n takes the wp_n level at the edge where a program or erase is accepted, and keeps it through the operation and any suspension, whatever wp_n does meanwhile.
- R11: Each request with cmd_valid at 1 produces exactly one one-cycle pulse, either cmd_accept or cmd_ignored, in the following cycle. An ignored request leaves ready_busy unchanged. With cmd_valid at 0, neither pulse appears.
- R12: A suspend while no operation runs, and a resume while not suspended, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A decoded request is present this cycle |
| cmd_kind | input | 2 | 00 program, 01 erase, 10 suspend, 11 resume |
| cmd_block | input | 6 | Target block index |
| wp_n | input | 1 | Write-protect pin, low protects blocks 0 to 48 |
| lock_bits | input | 50 | Per-block lock bits, 1 locks the block |
| ctl_finish | input | 1 | One-cycle pulse from the controller when an operation completes |
| supply_low | input | 1 | Supply-lockout flag, 1 while the supply is invalid |
| cmd_accept | output | 1 | One-cycle pulse: request accepted |
| cmd_ignored | output | 1 | One-cycle pulse: request refused |
| abort_req | output | 1 | One-cycle pulse: abort the operation in progress |
| ready_busy | output | 1 | 1 ready, 0 while an operation runs |
| op_wp_n | output | 1 | Write-protect level latched for the current operation |
| force_read | output | 1 | One-cycle pulse: return the command interpreter to read mode |

## Verification
The properties assume that supply_low is low while reset is asserted and on the first edge after it. Without that, a lockout release in the first cycle would have no earlier level to compare against. They also assume that ctl_finish pulses only while an operation runs. The bench meets both assumptions: it holds supply_low at 0 and ctl_finish at 0 throughout reset, and raises ctl_finish only after an accepted program or erase, or during a cycle whose expected behaviour is that the pulse ends the operation. Block indices up to 63 are driven on purpose so that the out-of-range path is exercised.

// File: rtl/pe_gate_pkg.sv
// Shared types for the program/erase command gate.
// Assumes a two-bit request code supplied by an upstream decoder.
package pe_gate_pkg;

    // Request codes; the encoding is fixed at the gate's input.
    typedef enum logic [1:0] {
        CMD_PROGRAM = 2'b00,
        CMD_ERASE   = 2'b01,
        CMD_SUSPEND = 2'b10,
        CMD_RESUME  = 2'b11
    } cmd_kind_e;

    // Operation tracking state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_SUSP = 2'b10
    } op_state_e;

    // True for the two request kinds that modify the array.
    function automatic logic is_modify(input cmd_kind_e k);
        return (k == CMD_PROGRAM) || (k == CMD_ERASE);
    endfunction

endpackage

// File: rtl/pe_protect_eval.sv
// Combinational permission check for a program/erase target block.
// Decides whether the addressed block may be modified, using its range,
// its lock bit and the hardware write-protect pin.
// Assumes the top block (index NUM_BLOCKS-1) is outside hardware protection.
module pe_protect_eval #(
    parameter int NUM_BLOCKS = 50,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic [BLK_W-1:0]      blk,
    input  logic                  wp_n,
    input  logic [NUM_BLOCKS-1:0] lock_bits,
    output logic                  blk_ok
);

    localparam int TOP_IDX = NUM_BLOCKS - 1;

    logic [NUM_BLOCKS-1:0] lock_hit;
    logic                  in_range;
    logic                  is_top;
    logic                  locked;
    logic                  hw_blocked;

    // One decoder slice per block: selects that block's lock bit.
    for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_lock_sel
        assign lock_hit[gi] = (blk == BLK_W'(gi)) && lock_bits[gi];
    end

    // Range, top-block and protection terms combined into one verdict.
    always_comb begin
        in_range   = (int'(blk) < NUM_BLOCKS);
        is_top     = (int'(blk) == TOP_IDX);
        locked     = |lock_hit;
        hw_blocked = !is_top && !wp_n;
        blk_ok     = in_range && !locked && !hw_blocked;
    end

endmodule

// File: rtl/pe_supply_track.sv
// Tracks the supply-lockout flag and produces a one-cycle request to
// return the command interpreter to read mode when the supply becomes valid.
// Assumes supply_low is already synchronised to clk.
module pe_supply_track (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    output logic force_read
);

    logic low_q;

    // Remember last sampled lockout level; pulse on its release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q      <= 1'b0;
            force_read <= 1'b0;
        end else begin
            low_q      <= supply_low;
            force_read <= low_q && !supply_low;
        end
    end

endmodule

// File: rtl/pe_op_fsm.sv
// Operation tracker and request arbiter for the command gate.
// Holds idle / running / suspended state, answers each request with an
// accept or ignored pulse, drives ready/busy, raises abort on lockout and
// latches the write-protect level for an accepted operation.
// Assumes ctl_finish is only pulsed while an operation runs.
module pe_op_fsm
    import pe_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_valid,
    input  cmd_kind_e cmd_kind,
    input  logic      target_ok,
    input  logic      wp_n,
    input  logic      ctl_finish,
    input  logic      lockout,
    output logic      cmd_accept,
    output logic      cmd_ignored,
    output logic      abort_req,
    output logic      ready_busy,
    output logic      op_wp_n
);

    op_state_e state_q;
    op_state_e state_d;
    logic      take;
    logic      take_modify;

    // Next-state and acceptance decision; lockout has top priority.
    always_comb begin
        state_d     = state_q;
        take        = 1'b0;
        take_modify = 1'b0;
        if (lockout) begin
            state_d = ST_IDLE;
        end else begin
            if (ctl_finish && state_q == ST_RUN) begin
                state_d = ST_IDLE;
            end
            if (cmd_valid) begin
                unique case (cmd_kind)
                    CMD_PROGRAM, CMD_ERASE: begin
                        if (state_q == ST_IDLE && target_ok) begin
                            take        = 1'b1;
                            take_modify = 1'b1;
                            state_d     = ST_RUN;
                        end
                    end
                    CMD_SUSPEND: begin
                        if (state_q == ST_RUN && !ctl_finish) begin
                            take    = 1'b1;
                            state_d = ST_SUSP;
                        end
                    end
                    CMD_RESUME: begin
                        if (state_q == ST_SUSP) begin
                            take    = 1'b1;
                            state_d = ST_RUN;
                        end
                    end
                    default: take = 1'b0;
                endcase
            end
        end
    end

    // State register and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cmd_accept  <= 1'b0;
            cmd_ignored <= 1'b0;
            abort_req   <= 1'b0;
            ready_busy  <= 1'b1;
            op_wp_n     <= 1'b1;
        end else begin
            state_q     <= state_d;
            cmd_accept  <= cmd_valid && take;
            cmd_ignored <= cmd_valid && !take;
            abort_req   <= lockout && (state_q != ST_IDLE);
            ready_busy  <= (state_d != ST_RUN);
            if (take_modify) begin
                op_wp_n <= wp_n;
            end
        end
    end

endmodule

// File: rtl/pe_cmd_gate.sv
// Program/erase command gate, top level.
// Combines the block permission check, the operation tracker and the
// supply-lockout tracker. All outputs are registered; a request seen at an
// edge is answered after that edge.
// Assumes all inputs are synchronous to clk.
module pe_cmd_gate
    import pe_gate_pkg::*;
#(
    parameter int NUM_BLOCKS = 50,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_kind,
    input  logic [BLK_W-1:0]      cmd_block,
    input  logic                  wp_n,
    input  logic [NUM_BLOCKS-1:0] lock_bits,
    input  logic                  ctl_finish,
    input  logic                  supply_low,
    output logic                  cmd_accept,
    output logic                  cmd_ignored,
    output logic                  abort_req,
    output logic                  ready_busy,
    output logic                  op_wp_n,
    output logic                  force_read
);

    logic      target_ok;
    cmd_kind_e kind;

    // Request code viewed as the shared enum.
    assign kind = cmd_kind_e'(cmd_kind);

    pe_protect_eval #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .BLK_W     (BLK_W)
    ) u_protect (
        .blk      (cmd_block),
        .wp_n     (wp_n),
        .lock_bits(lock_bits),
        .blk_ok   (target_ok)
    );

    pe_op_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_kind   (kind),
        .target_ok  (target_ok),
        .wp_n       (wp_n),
        .ctl_finish (ctl_finish),
        .lockout    (supply_low),
        .cmd_accept (cmd_accept),
        .cmd_ignored(cmd_ignored),
        .abort_req  (abort_req),
        .ready_busy (ready_busy),
        .op_wp_n    (op_wp_n)
    );

    pe_supply_track u_supply (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_low(supply_low),
        .force_read(force_read)
    );

endmodule

// File: rtl/pe_cmd_gate_chk.sv
// Property checker for the command gate, attached by bind.
// Assumes supply_low is low during reset and ctl_finish pulses only while
// an operation runs.
module pe_cmd_gate_chk #(
    parameter int NUM_BLOCKS = 50,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid,
    input logic [1:0]            cmd_kind,
    input logic [BLK_W-1:0]      cmd_block,
    input logic                  wp_n,
    input logic [NUM_BLOCKS-1:0] lock_bits,
    input logic                  ctl_finish,
    input logic                  supply_low,
    input logic                  cmd_accept,
    input logic                  cmd_ignored,
    input logic                  abort_req,
    input logic                  ready_busy,
    input logic                  op_wp_n,
    input logic                  force_read
);

    localparam int TOP_IDX = NUM_BLOCKS - 1;

    logic modify_req;
    logic blk_locked;
    assign modify_req = cmd_valid && !cmd_kind[1];
    assign blk_locked = (int'(cmd_block) < NUM_BLOCKS) && lock_bits[cmd_block];

    assert_one_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> $countones({cmd_accept, cmd_ignored}) == 1);

    assert_no_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !cmd_accept && !cmd_ignored);

    assert_wp_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        modify_req && !supply_low && !wp_n && int'(cmd_block) < TOP_IDX |=> !cmd_accept);

    assert_lock_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        modify_req && !supply_low && blk_locked |=> !cmd_accept);

    assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        modify_req && int'(cmd_block) >= NUM_BLOCKS |=> !cmd_accept);

    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_busy && !supply_low && !ctl_finish && !cmd_valid |=> !ready_busy);

    assert_finish_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_busy && ctl_finish && !supply_low |=> ready_busy);

    assert_lockout_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> ready_busy && !cmd_accept);

    assert_abort_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !abort_req);

    assert_release_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_low) |=> force_read);

    assert_wp_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ready_busy) && !ready_busy |-> $stable(op_wp_n));

endmodule

bind pe_cmd_gate pe_cmd_gate_chk #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .BLK_W     (BLK_W)
) u_chk (.*);

// File: tb/pe_cmd_gate_bench.sv
`timescale 1ns/1ps
module pe_cmd_gate_bench;

    localparam int NB = 50;
    localparam int BW = 6;

    // Stimulus and expected {accept, ignored, ready_busy, abort, force_read, op_wp_n}
    typedef struct packed {
        logic          v;
        logic [1:0]    k;
        logic [BW-1:0] b;
        logic          lk;
        logic          wp;
        logic          fin;
        logic          slo;
        logic [5:0]    exp;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t TBL [0:NV-1] = '{
        '{1'b1, 2'd0, 6'd3,  1'b0, 1'b1, 1'b0, 1'b0, 6'b100001}, // 0  R3 R6 accept
        '{1'b0, 2'd0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 6'b000001}, // 1  R11 quiet
        '{1'b1, 2'd1, 6'd5,  1'b0, 1'b1, 1'b0, 1'b0, 6'b010001}, // 2  R7 busy reject
        '{1'b0, 2'd0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 6'b001001}, // 3  R6 finish
        '{1'b1, 2'd1, 6'd10, 1'b0, 1'b0, 1'b0, 1'b0, 6'b011001}, // 4  R2
        '{1'b1, 2'd0, 6'd48, 1'b0, 1'b0, 1'b0, 1'b0, 6'b011001}, // 5  R2 boundary
        '{1'b1, 2'd0, 6'd49, 1'b0, 1'b0, 1'b0, 1'b0, 6'b100000}, // 6  R4 R10
        '{1'b0, 2'd0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 6'b000000}, // 7  R10 pin moves
        '{1'b1, 2'd2, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 6'b101000}, // 8  R7 suspend
        '{1'b1, 2'd0, 6'd2,  1'b0, 1'b1, 1'b0, 1'b0, 6'b011000}, // 9  R7 no new op
        '{1'b1, 2'd3, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 6'b100000}, // 10 R7 resume
        '{1'b0, 2'd0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 6'b001000}, // 11 R6 finish
        '{1'b1, 2'd0, 6'd49, 1'b1, 1'b1, 1'b0, 1'b0, 6'b011000}, // 12 R4 locked top
        '{1'b1, 2'd1, 6'd7,  1'b1, 1'b1, 1'b0, 1'b0, 6'b011000}, // 13 R3 locked
        '{1'b1, 2'd1, 6'd7,  1'b0, 1'b1, 1'b0, 1'b0, 6'b100001}, // 14 R3 unlocked
        '{1'b0, 2'd0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'b001101}, // 15 R8 abort
        '{1'b1, 2'd0, 6'd1,  1'b0, 1'b1, 1'b0, 1'b1, 6'b011001}, // 16 R8 ignored
        '{1'b0, 2'd0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 6'b001011}, // 17 R9 release
        '{1'b0, 2'd0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 6'b001001}, // 18 R9 one cycle
        '{1'b1, 2'd2, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 6'b011001}, // 19 R12 suspend idle
        '{1'b1, 2'd3, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 6'b011001}, // 20 R12 resume idle
        '{1'b1, 2'd0, 6'd50, 1'b0, 1'b1, 1'b0, 1'b0, 6'b011001}, // 21 R5
        '{1'b1, 2'd1, 6'd63, 1'b0, 1'b1, 1'b0, 1'b0, 6'b011001}, // 22 R5
        '{1'b1, 2'd0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 6'b100001}, // 23 R3 block 0
        '{1'b1, 2'd0, 6'd4,  1'b0, 1'b1, 1'b1, 1'b0, 6'b011001}, // 24 R7 op with finish
        '{1'b0, 2'd0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'b001001}, // 25 R8 no abort idle
        '{1'b0, 2'd0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 6'b001011}, // 26 R9
        '{1'b1, 2'd0, 6'd49, 1'b0, 1'b1, 1'b0, 1'b0, 6'b100001}, // 27 R4 top wp high
        '{1'b1, 2'd2, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 6'b011001}  // 28 R7 suspend+finish
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_valid;
    logic [1:0]    cmd_kind;
    logic [BW-1:0] cmd_block;
    logic          wp_n;
    logic [NB-1:0] lock_bits;
    logic          ctl_finish;
    logic          supply_low;
    logic          cmd_accept, cmd_ignored, abort_req, ready_busy, op_wp_n, force_read;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pe_cmd_gate u_pe_cmd_gate (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_block(cmd_block), .wp_n(wp_n), .lock_bits(lock_bits),
        .ctl_finish(ctl_finish), .supply_low(supply_low),
        .cmd_accept(cmd_accept), .cmd_ignored(cmd_ignored), .abort_req(abort_req),
        .ready_busy(ready_busy), .op_wp_n(op_wp_n), .force_read(force_read)
    );

    // Apply one stimulus at the falling edge, sample after the next rising edge.
    task automatic apply(input vec_t t);
        cmd_valid  = t.v;
        cmd_kind   = t.k;
        cmd_block  = t.b;
        wp_n       = t.wp;
        ctl_finish = t.fin;
        supply_low = t.slo;
        lock_bits  = '0;
        if (int'(t.b) < NB) lock_bits[t.b] = t.lk;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [5:0] exp);
        logic [5:0] got;
        got = {cmd_accept, cmd_ignored, ready_busy, abort_req, force_read, op_wp_n};
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        cmd_valid = 1'b0; cmd_kind = 2'd0; cmd_block = '0; wp_n = 1'b1;
        lock_bits = '0; ctl_finish = 1'b0; supply_low = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset state", 6'b001001);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset release", 6'b001001);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            check($sformatf("vector %0d (R2..R12)", i), TBL[i].exp);
        end
        idle_inputs();
        @(negedge clk);
        // Vector 27 op finished? No: it was suspended attempt ignored, op still ran,
        // and finish in 28 ended it.
        check("R6 idle after finish", 6'b001001);

        // Directed: abort while suspended (R8)
        apply('{1'b1, 2'd0, 6'd20, 1'b0, 1'b0, 1'b0, 1'b0, 6'b0});
        check("R2 wp low block 20", 6'b011001);
        apply('{1'b1, 2'd0, 6'd20, 1'b0, 1'b1, 1'b0, 1'b0, 6'b0});
        check("R3 accept block 20", 6'b100001);
        apply('{1'b1, 2'd2, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b0});
        check("R10 suspend pin low", 6'b101001);
        apply('{1'b0, 2'd0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b1, 6'b0});
        check("R8 abort from suspend", 6'b001101);
        apply('{1'b0, 2'd0, 6'd0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b0});
        check("R9 release after abort", 6'b001011);
        apply('{1'b1, 2'd3, 6'd0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b0});
        check("R12 resume after abort", 6'b011001);

        // Directed: reset in the middle of an operation (R1)
        apply('{1'b1, 2'd1, 6'd30, 1'b0, 1'b0, 1'b0, 1'b0, 6'b0});
        check("R2 erase wp low", 6'b011001);
        apply('{1'b1, 2'd1, 6'd49, 1'b0, 1'b0, 1'b0, 1'b0, 6'b0});
        check("R4 erase top wp low", 6'b100000);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-operation", 6'b001001);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 6'b001001);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired got=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule